// File: doc/BRIEF.md
# UART Receive Queue with Idle Timeout

This block sits between a UART deserializer and the reader of received characters. Each character the deserializer completes is written into a small first-in first-out queue. The reader sees the oldest character on `rd_data` and removes it with `rd_en`. Along with the data, the block reports how many characters are held, whether the queue is full, and whether a character has been lost.

A receive request, `rx_req`, rises once the fill level reaches a programmable trigger. The trigger is a 3-bit ratio of the queue depth. An idle timer counts frame-time ticks while characters sit in the queue and nothing is written or read. After 8*(N+1) such ticks, where N is a 4-bit value, it sets a sticky timeout flag. That flag lets the reader collect a short tail of data that never reaches the trigger. Software clears the flag by writing the status back with the timeout bit set. A queue flush input empties the queue and clears the error and timeout flags.

Top module: `rxq_top`

## Requirements
- R1: After reset, count is 0, ready, full, error, request and timeout are all 0.
- R2: Characters are read in write order. `rd_data` shows the oldest held character. A read while empty has no effect. A write and a read in the same cycle while non-empty leave the count unchanged.
- R3: `rx_count` is the number of held characters, zero-extended to 8 bits. It never exceeds DEPTH. `rx_full` is 1 exactly when the count equals DEPTH.
- R4: A write while full, with no read in the same cycle, is discarded. The count and the head character stay unchanged, and `rx_err` becomes 1. `rx_err` stays 1 until reset or flush. A write while full together with a read is accepted.
- R5: `rx_req` is 1 when count >= max(1, ratio*DEPTH/8). With DEPTH=16 this is 2*ratio, and ratio 0 means one entry.
- R6: With `tmo_en`=1 and the queue non-empty, `tmo_flag` becomes 1 after the edge of the 8*(`tmo_n`+1)-th `frame_tick` that arrives with no write and no accepted read.
- R7: The idle count restarts on every write strobe and every accepted read. It does not advance while the queue is empty or `tmo_en` is 0.
- R8: `tmo_flag` is sticky. A cycle with `status_wr`=1 and `tmo_wb`=1 clears it. `status_wr` with `tmo_wb`=0 leaves it set. A new timeout in the same cycle as a clear wins.
- R9: `flush` empties the queue and clears `rx_err` and `tmo_flag`. A write in the same cycle as a flush is dropped.
- R10: `rx_ready` is 1 exactly when at least one character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the queue and clears the flags |
| wr_en | input | 1 | Character write strobe from the deserializer |
| wr_data | input | 8 | Character to store |
| rd_en | input | 1 | Removes the oldest character |
| rd_data | output | 8 | Oldest held character |
| frame_tick | input | 1 | One-cycle pulse per frame time |
| trig_ratio | input | 3 | Fill trigger ratio, 0 to 7 |
| tmo_n | input | 4 | Timeout value N; the limit is 8*(N+1) frame ticks |
| tmo_en | input | 1 | Enables the idle timer |
| status_wr | input | 1 | Status write-back strobe |
| tmo_wb | input | 1 | Timeout bit of the written status; 1 clears the flag |
| rx_ready | output | 1 | At least one character is held |
| rx_count | output | 8 | Number of held characters |
| rx_full | output | 1 | Queue full |
| rx_err | output | 1 | Sticky flag: a character was discarded |
| rx_req | output | 1 | Fill level has reached the trigger |
| tmo_flag | output | 1 | Sticky idle-timeout status |

## Verification
Two pairs of actions can land in the same cycle. One pair is an overflow write and a read on a full queue. The bench provokes it by filling the queue to DEPTH and then issuing a write alone and a write with a read. It judges the outcome by the count, the head character and the error flag. The other pair is a timeout expiry and a software clear. The bench brings the idle count to one tick short of the limit, then applies the final tick in the same cycle as a status write-back. The flag must read 1 afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned TMO_CW = 8;

    typedef struct packed {
        logic [TMO_CW-1:0] ticks;
        logic              flag;
    } rxq_tmo_state_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          rd_ok,
    output logic          err
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          err;
    } store_t;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    store_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_rd, do_wr;

    always_comb begin
        s_d   = s_q;
        do_rd = rd_en && (s_q.cnt != '0);
        do_wr = wr_en && ((s_q.cnt != FULL_CNT) || do_rd);
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_wr) s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + 1'b1;
            if (do_rd) s_d.rp = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + 1'b1;
            if (do_wr && !do_rd) s_d.cnt = s_q.cnt + 1'b1;
            else if (do_rd && !do_wr) s_d.cnt = s_q.cnt - 1'b1;
            if (wr_en && !do_wr) s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem_q[s_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[s_q.rp];
    assign count   = s_q.cnt;
    assign rd_ok   = do_rd && !flush;
    assign err     = s_q.err;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);

    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush && s_q.cnt == FULL_CNT) |=> (s_q.cnt == FULL_CNT) && s_q.err);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !flush) |=> s_q.err);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.cnt == '0) && !s_q.err);

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic [2:0]    ratio,
    input  logic [CW-1:0] count,
    output logic          req
);

    int unsigned scaled;
    int unsigned level;

    always_comb begin
        scaled = (int'(ratio) * DEPTH) / 8;
        level  = (scaled == 0) ? 1 : scaled;
        req    = int'(count) >= level;
    end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       restart,
    input  logic       active,
    input  logic       tick,
    input  logic [3:0] n_val,
    input  logic       clr,
    output logic       flag
);

    rxq_tmo_state_t t_d, t_q;
    logic [TMO_CW-1:0] limit;
    logic              fire;

    always_comb begin
        t_d   = t_q;
        limit = ({{(TMO_CW-4){1'b0}}, n_val} + 1'b1) << 3;
        fire  = active && !restart && tick && ((t_q.ticks + 1'b1) == limit);
        if (flush) begin
            t_d = '0;
        end else begin
            if (restart || !active)                t_d.ticks = '0;
            else if (tick && (t_q.ticks < limit))  t_d.ticks = t_q.ticks + 1'b1;
            if (fire)      t_d.flag = 1'b1;
            else if (clr)  t_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign flag = t_q.flag;

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.flag && !clr && !flush) |=> t_q.flag);

    p_fire_needs_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.flag) |-> $past(active) && $past(tick));

    p_idle_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !flush) |=> (t_q.ticks == '0));

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    input  logic              frame_tick,
    input  logic [2:0]        trig_ratio,
    input  logic [3:0]        tmo_n,
    input  logic              tmo_en,
    input  logic              status_wr,
    input  logic              tmo_wb,
    output logic              rx_ready,
    output logic [7:0]        rx_count,
    output logic              rx_full,
    output logic              rx_err,
    output logic              rx_req,
    output logic              tmo_flag
);

    logic [CW-1:0] cnt;
    logic          rd_ok;

    rxq_store #(.DEPTH(DEPTH), .DW(CHAR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (cnt),
        .rd_ok   (rd_ok),
        .err     (rx_err)
    );

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .ratio (trig_ratio),
        .count (cnt),
        .req   (rx_req)
    );

    rxq_idle_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .restart (wr_en || rd_ok),
        .active  (tmo_en && (cnt != '0)),
        .tick    (frame_tick),
        .n_val   (tmo_n),
        .clr     (status_wr && tmo_wb),
        .flag    (tmo_flag)
    );

    assign rx_ready = cnt != '0;
    assign rx_full  = cnt == CW'(DEPTH);
    assign rx_count = 8'(cnt);

    p_req_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> rx_ready);

    p_full_is_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_ready);

endmodule

// File: tb/rxq_top_tb.sv
module rxq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int NVEC       = 8;
    // {wr, rd, data, expected count, expected head}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA1, 8'd1, 8'hA1},
        {1'b1, 1'b0, 8'hB2, 8'd2, 8'hA1},
        {1'b1, 1'b1, 8'hC3, 8'd2, 8'hB2},
        {1'b0, 1'b1, 8'h00, 8'd1, 8'hC3},
        {1'b0, 1'b1, 8'h00, 8'd0, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'd0, 8'h00},
        {1'b1, 1'b0, 8'hD4, 8'd1, 8'hD4},
        {1'b0, 1'b1, 8'h00, 8'd0, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic flush = 0, wr_en = 0, rd_en = 0, frame_tick = 0;
    logic tmo_en = 0, status_wr = 0, tmo_wb = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] trig_ratio = 0;
    logic [3:0] tmo_n = 0;
    logic [7:0] rd_data, rx_count;
    logic rx_ready, rx_full, rx_err, rx_req, tmo_flag;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .frame_tick(frame_tick),
        .trig_ratio(trig_ratio), .tmo_n(tmo_n), .tmo_en(tmo_en),
        .status_wr(status_wr), .tmo_wb(tmo_wb), .rx_ready(rx_ready),
        .rx_count(rx_count), .rx_full(rx_full), .rx_err(rx_err),
        .rx_req(rx_req), .tmo_flag(tmo_flag)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Applies inputs for one clock edge, then leaves outputs settled for checking.
    task automatic step(input logic w, input logic [7:0] d, input logic r,
                        input logic tk, input logic sw, input logic wb, input logic fl);
        wr_en = w; wr_data = d; rd_en = r; frame_tick = tk;
        status_wr = sw; tmo_wb = wb; flush = fl;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; frame_tick = 0; status_wr = 0; tmo_wb = 0; flush = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 count", rx_count, 0);
        check("R1 flags", {rx_ready, rx_full, rx_err, rx_req, tmo_flag}, 0);

        // R2 R10 R5 vector walk, ratio 0 means one entry
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][25], VEC[i][23:16], VEC[i][24], 0, 0, 0, 0);
            check($sformatf("R2 count v%0d", i), rx_count, VEC[i][15:8]);
            if (VEC[i][15:8] != 0) check($sformatf("R2 head v%0d", i), rd_data, VEC[i][7:0]);
            check($sformatf("R10 ready v%0d", i), rx_ready, VEC[i][15:8] != 0);
            check($sformatf("R5 req ratio0 v%0d", i), rx_req, VEC[i][15:8] >= 1);
        end

        // R5 R3 fill with ratio 3 (level 6)
        trig_ratio = 3'd3;
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
            if (i == 4) check("R5 req below level", rx_req, 0);
            if (i == 5) check("R5 req at level", rx_req, 1);
            if (i == DEPTH-2) check("R3 not full", rx_full, 0);
        end
        check("R3 full", rx_full, 1);
        check("R3 count full", rx_count, DEPTH);
        trig_ratio = 3'd7;
        check("R5 ratio7 at 16", rx_req, 1);

        // R4 overflow discarded
        check("R4 err before", rx_err, 0);
        step(1, 8'hEE, 0, 0, 0, 0, 0);
        check("R4 count kept", rx_count, DEPTH);
        check("R4 head kept", rd_data, 8'h10);
        check("R4 err set", rx_err, 1);
        step(1, 8'hEF, 1, 0, 0, 0, 0);
        check("R4 wr+rd when full count", rx_count, DEPTH);
        check("R4 wr+rd when full head", rd_data, 8'h11);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0);
        check("R2 drained", rx_count, 0);
        check("R4 err sticky", rx_err, 1);

        // R9 flush with write
        step(1, 8'h55, 0, 0, 0, 0, 0);
        step(1, 8'h66, 0, 0, 0, 0, 1);
        check("R9 flush count", rx_count, 0);
        check("R9 flush err", rx_err, 0);

        // R6 timeout N=0 -> 8 ticks
        trig_ratio = 0; tmo_en = 1; tmo_n = 0;
        step(1, 8'h21, 0, 0, 0, 0, 0);
        ticks(7);
        check("R6 before limit", tmo_flag, 0);
        ticks(1);
        check("R6 at limit", tmo_flag, 1);

        // R8 write-back with bit clear ignored, with bit set clears
        step(0, 0, 0, 0, 1, 0, 0);
        check("R8 wb zero keeps", tmo_flag, 1);
        step(0, 0, 0, 0, 1, 1, 0);
        check("R8 wb one clears", tmo_flag, 0);

        // R7 restart on write
        step(1, 8'h22, 0, 0, 0, 0, 0);
        ticks(5);
        step(1, 8'h23, 0, 0, 0, 0, 0);
        ticks(7);
        check("R7 restart by write", tmo_flag, 0);
        ticks(1);
        check("R7 fire after restart", tmo_flag, 1);
        step(0, 0, 0, 0, 1, 1, 0);

        // R7 restart on read
        step(0, 0, 1, 0, 0, 0, 0);
        ticks(7);
        check("R7 restart by read", tmo_flag, 0);

        // R8 set wins over clear in same cycle
        step(0, 0, 0, 1, 1, 1, 0);
        check("R8 set beats clear", tmo_flag, 1);
        step(0, 0, 0, 0, 1, 1, 0);

        // R7 disabled does not count
        tmo_en = 0;
        ticks(20);
        check("R7 disabled", tmo_flag, 0);

        // R7 empty does not count
        tmo_en = 1;
        step(0, 0, 0, 0, 0, 0, 1);
        ticks(20);
        check("R7 empty", tmo_flag, 0);

        // R6 N=1 -> 16 ticks
        tmo_n = 4'd1;
        step(1, 8'h31, 0, 0, 0, 0, 0);
        ticks(15);
        check("R6 N1 before limit", tmo_flag, 0);
        ticks(1);
        check("R6 N1 at limit", tmo_flag, 1);

        // R9 flush clears timeout
        step(0, 0, 0, 0, 0, 0, 1);
        check("R9 flush timeout", tmo_flag, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule